// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous up-counter built from a parameterized number of identical 4-bit stages. Each stage has an active-low clear that acts at once, without waiting for the clock, and an active-low parallel load that acts on the rising clock edge. Two active-high enables control counting. The shared enable goes to every stage. The chain enable feeds the lowest stage, and each higher stage takes the carry of the stage below it as its chain enable.

A stage counts when load is inactive and both of its enables are high at a rising edge. A load takes priority over both enables. Each stage drives a carry output that is high whenever its chain enable is high and its value is all ones. The carry does not depend on the shared enable and has no register. Because of this, the stages of a wide counter all step on the same clock edge, and no extra gating is needed between them.

Top module: `casc_bin_counter`

## Requirements
- R1: While `clr_n` is low, `count` is zero at once, without a clock edge and whatever the levels of load and the enables. Clear has priority over every other function.
- R2: When `ld_n` is low at a rising edge, `count` takes the value of `din` after that edge, whatever the levels of `en_shared` and `en_chain`.
- R3: When `ld_n` is high at a rising edge, `count` increments by one if `en_shared` and `en_chain` are both high. If either enable is low, `count` holds. Every bit changes on the same edge.
- R4: An enabled count from the all-ones value, 255 with the default parameters, wraps to zero.
- R5: The carry of a stage, seen on `stage_carry[i]`, is high exactly when that stage's chain enable is high and its 4-bit value is 15. The carry is combinational and does not depend on `en_shared`.
- R6: Stage 0 takes `en_chain` as its chain enable. Stage i takes `stage_carry[i-1]`. `carry_out` equals the carry of the top stage. Together the stages form one synchronous binary counter.
- R7: Changes on `ld_n`, `en_shared` or `en_chain` that are gone again before the next rising edge leave `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter acts on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| en_shared | input | 1 | Count enable shared by all stages |
| en_chain | input | 1 | Chain enable into stage 0; also gates the carries |
| din | input | STAGE_W*NUM_STAGES (8) | Parallel load data |
| count | output | STAGE_W*NUM_STAGES (8) | Counter value |
| stage_carry | output | NUM_STAGES (2) | Carry output of each stage |
| carry_out | output | 1 | Carry of the top stage, for chaining to more counters |

## Verification
The hardest case to reach from the ports is the full rollover of the whole chain. Every stage must be at all ones while the chain enable is high, and the next edge must clear all stages at once. The bench loads 0xFE and counts through 0xFF to 0x00, checking the stage carries and `carry_out` at each edge. It also loads 0x0E to check a single nibble carry on its own, and it pulls clear low between edges so that the asynchronous path is checked without any clock edge.

// File: rtl/cbc_pkg.sv
`timescale 1ns/1ps
package cbc_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_COUNT = 2'd2
  } stage_mode_e;

  // Load beats both enables; counting needs both enables high.
  function automatic stage_mode_e decode_mode(input logic ld_n,
                                              input logic en_p,
                                              input logic en_c);
    if (!ld_n)            return MODE_LOAD;
    else if (en_p && en_c) return MODE_COUNT;
    else                  return MODE_HOLD;
  endfunction

endpackage

// File: rtl/cbc_carry.sv
`timescale 1ns/1ps
module cbc_carry #(
  parameter int W = 4
) (
  input  logic         chain_in,
  input  logic [W-1:0] q,
  output logic         carry
);
  logic at_top;

  assign at_top = (q == {W{1'b1}});
  assign carry  = chain_in & at_top;

  // R5: no carry without the chain enable, and only from all ones
  always_comb begin
    if (!chain_in) assert_carry_gated_R5: assert (!carry);
    if (carry)     assert_carry_full_R5: assert ($countones(q) == W);
  end
endmodule

// File: rtl/cbc_stage.sv
`timescale 1ns/1ps
module cbc_stage
  import cbc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_p,
  input  logic         chain_in,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         carry
);
  stage_mode_e mode;
  logic        load_evt;
  logic        count_evt;
  logic [W-1:0] q_inc;

  assign mode      = decode_mode(ld_n, en_p, chain_in);
  assign load_evt  = (mode == MODE_LOAD);
  assign count_evt = (mode == MODE_COUNT);
  assign q_inc     = q + {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)         q <= '0;
    else if (load_evt)  q <= d;
    else if (count_evt) q <= q_inc;
  end

  cbc_carry #(.W(W)) u_carry (
    .chain_in (chain_in),
    .q        (q),
    .carry    (carry)
  );

  // R1: clear holds the stage at zero
  always @(negedge clk) begin
    if (!clr_n) assert_clear_zero_R1: assert (q == '0);
  end

  // R2: load takes the data
  assert_load_data_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> q == $past(d));

  // R3: count increments, with wrap (R4)
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_p && chain_in) |=> q == W'($past(q) + 1'b1));

  // R3: hold when an enable is low
  assert_hold_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_p && chain_in)) |=> $stable(q));
endmodule

// File: rtl/casc_bin_counter.sv
`timescale 1ns/1ps
module casc_bin_counter #(
  parameter int STAGE_W    = 4,
  parameter int NUM_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          clr_n,
  input  logic                          ld_n,
  input  logic                          en_shared,
  input  logic                          en_chain,
  input  logic [STAGE_W*NUM_STAGES-1:0] din,
  output logic [STAGE_W*NUM_STAGES-1:0] count,
  output logic [NUM_STAGES-1:0]         stage_carry,
  output logic                          carry_out
);
  localparam int TOTAL_W = STAGE_W * NUM_STAGES;

  logic [NUM_STAGES-1:0] chain;

  assign chain[0] = en_chain;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    if (i > 0) begin : g_link
      assign chain[i] = stage_carry[i-1];
      // R6: a higher carry needs the carry below it
      assert_chain_order_R6: assert property (@(posedge clk) disable iff (!clr_n)
        stage_carry[i] |-> stage_carry[i-1]);
    end
    cbc_stage #(.W(STAGE_W)) u_stage (
      .clk      (clk),
      .clr_n    (clr_n),
      .ld_n     (ld_n),
      .en_p     (en_shared),
      .chain_in (chain[i]),
      .d        (din[i*STAGE_W +: STAGE_W]),
      .q        (count[i*STAGE_W +: STAGE_W]),
      .carry    (stage_carry[i])
    );
  end

  assign carry_out = stage_carry[NUM_STAGES-1];

  // R4/R6: the whole chain steps as one counter
  assert_wide_step_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_shared && en_chain) |=> count == TOTAL_W'($past(count) + 1'b1));
endmodule

// File: tb/sim_casc_bin_counter.sv
`timescale 1ns/1ps
module sim_casc_bin_counter;
  logic       clk = 1'b0;
  logic       clr_n, ld_n, en_shared, en_chain;
  logic [7:0] din;
  logic [7:0] count;
  logic [1:0] stage_carry;
  logic       carry_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [7:0] model = 8'h00;

  always #2.5 clk = ~clk;

  casc_bin_counter #(.STAGE_W(4), .NUM_STAGES(2)) u0 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_shared(en_shared),
    .en_chain(en_chain), .din(din), .count(count),
    .stage_carry(stage_carry), .carry_out(carry_out)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: one rising edge with the present inputs.
  task automatic step();
    if (!clr_n)                    model = 8'h00;
    else if (!ld_n)                model = din;
    else if (en_shared && en_chain) model = model + 8'd1;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_all(string tag);
    chk({tag, " count"}, count, model);
    chk({tag, " carry0"}, stage_carry[0], en_chain && model[3:0] == 4'hF);
    chk({tag, " carry1"}, stage_carry[1], en_chain && model == 8'hFF);
    chk({tag, " carry_out"}, carry_out, en_chain && model == 8'hFF);
  endtask

  task automatic t_reset();
    chk("R1 reset", count, 8'h00);
    clr_n = 1'b1;
    step();
    chk_all("R1 after release");
  endtask

  task automatic t_load();
    ld_n = 1'b0; din = 8'hA5; en_shared = 1'b0; en_chain = 1'b0;
    step(); chk_all("R2 load enables low");
    din = 8'h3C; en_shared = 1'b1; en_chain = 1'b1;
    step(); chk_all("R2 load enables high");
    ld_n = 1'b1;
  endtask

  task automatic t_count();
    ld_n = 1'b0; din = 8'h07; step();
    ld_n = 1'b1; en_shared = 1'b1; en_chain = 1'b1;
    for (int k = 0; k < 12; k++) begin
      step(); chk_all("R3 count");
    end
  endtask

  task automatic t_hold();
    en_shared = 1'b0; en_chain = 1'b1;
    ld_n = 1'b0; din = 8'h2F; step(); ld_n = 1'b1;
    step(); chk_all("R3 hold shared low");
    chk("R5 carry ignores shared enable", stage_carry[0], 1'b1);
    en_shared = 1'b1; en_chain = 1'b0;
    step(); chk_all("R3 hold chain low");
    chk("R5 carry gated by chain", stage_carry[0], 1'b0);
  endtask

  task automatic t_nibble();
    en_shared = 1'b1; en_chain = 1'b1;
    ld_n = 1'b0; din = 8'h0E; step(); ld_n = 1'b1;
    step(); chk_all("R6 low nibble full");
    chk("R6 nibble carry", stage_carry, 2'b01);
    step(); chk_all("R6 upper stage steps");
    chk("R6 count after nibble", count, 8'h10);
  endtask

  task automatic t_rollover();
    en_shared = 1'b1; en_chain = 1'b1;
    ld_n = 1'b0; din = 8'hFE; step(); ld_n = 1'b1;
    step(); chk_all("R4 at max");
    chk("R6 carry_out at max", carry_out, 1'b1);
    step(); chk_all("R4 wrap");
    chk("R4 wrap value", count, 8'h00);
  endtask

  task automatic t_glitch();
    en_shared = 1'b0; en_chain = 1'b0;
    ld_n = 1'b0; din = 8'h55; step(); ld_n = 1'b1;
    din = 8'hAA;
    #0.5 ld_n = 1'b0; en_shared = 1'b1; en_chain = 1'b1;
    #1   ld_n = 1'b1; en_shared = 1'b0; en_chain = 1'b0;
    step(); chk_all("R7 glitch ignored");
    chk("R7 count kept", count, 8'h55);
  endtask

  task automatic t_mid_clear();
    en_shared = 1'b1; en_chain = 1'b1;
    ld_n = 1'b0; din = 8'h9B; step(); ld_n = 1'b1;
    #0.5 clr_n = 1'b0;
    #0.5 chk("R1 clear without edge", count, 8'h00);
    model = 8'h00;
    ld_n = 1'b0;
    step(); chk("R1 clear beats load", count, 8'h00);
    clr_n = 1'b1; ld_n = 1'b1;
    step(); chk_all("R1 count after clear");
  endtask

  initial begin
    clr_n = 1'b0; ld_n = 1'b1; en_shared = 1'b0; en_chain = 1'b0; din = 8'h00;
    @(posedge clk); #1;
    t_reset();
    t_load();
    t_count();
    t_hold();
    t_nibble();
    t_rollover();
    t_glitch();
    t_mid_clear();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule